// File: doc/BRIEF.md
# Atomic 64-Byte Store Issue Unit

This unit runs one atomic 64-byte store-with-status operation for a processor pipeline. When `op_start` is seen in the idle state, it does four things in that one cycle. It checks the register-field encoding and the feature enable. It builds a 512-bit payload from eight consecutive 64-bit source registers, where the low 32 bits of the first register are replaced by a 32-bit accelerator-data value. It picks the base address from a general register or from the stack pointer. It records all of this in registers.

If a check fails, the unit raises a one-cycle fault and no memory request goes out. If every check passes, the unit issues one valid/ready request to the memory port. It then waits for a single 64-bit status beat and writes that status back to register `op_rs`, unless `op_rs` names the zero register.

The FSM has five states:
- `IDLE`
- `FAULT`
- `REQ`
- `WAIT`
- `DONE`

It has six transitions:
- `IDLE` to `FAULT` on a start that fails a check.
- `IDLE` to `REQ` on a start that passes every check.
- `REQ` to `WAIT` when `mem_req_ready` is high.
- `WAIT` to `DONE` when `mem_rsp_valid` is high.
- `FAULT` to `IDLE` unconditionally.
- `DONE` to `IDLE` unconditionally.

Top module: `st64_issue_unit`

## Requirements
- R1: The request payload, from bit 511 down to bit 0, is `src_regs[511:64]` (registers t+7 down to t+1), then `src_regs[63:32]`, then `accdata[31:0]`.
- R2: If `op_rt[4:3]` is 2'b11 or `op_rt[0]` is 1, the unit gives `fault_valid` with `fault_code` 1 (illegal), and `mem_req_valid` stays low.
- R3: If `feat_en` is 0 at start, the unit gives `fault_code` 1 and issues no request.
- R4: If `big_endian` is 1, each 64-bit doubleword of the payload is byte-reversed on its own, and this includes the merged first doubleword.
- R5: If `op_rn` is 31, the address is `sp` and `mem_req_tag_check` is 0. Otherwise the address is `base_gpr` and `mem_req_tag_check` is 1.
- R6: If `op_rn` is 31 and `sp[3:0]` is nonzero, the unit gives `fault_code` 2 (stack misalignment) and issues no request.
- R7: If the selected address has a nonzero value in bits 5:0, the unit gives `fault_code` 3 (misaligned) and issues no request. Fault priority is code 1, then code 2, then code 3.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, the request address and data stay stable.
- R9: On the cycle after the response, `wb_valid` pulses with `wb_idx` equal to `op_rs` and `wb_data` equal to the status exactly as received. An all-ones status is passed through unchanged.
- R10: If `op_rs` is 31, `wb_valid` stays low, but `op_done` still pulses.
- R11: `busy` is high from start until completion, and `op_start` has no effect while `busy` is high.
- R12: Changes to the register inputs after the start cycle do not change the issued address or payload.
- R13: After reset, `busy`, `mem_req_valid`, `wb_valid`, `fault_valid` and `op_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start | input | 1 | Start pulse; taken only in `IDLE` |
| op_rs | input | 5 | Status destination register index |
| op_rt | input | 5 | First source register index |
| op_rn | input | 5 | Base register index (31 selects the stack pointer) |
| big_endian | input | 1 | Byte-reverse each doubleword |
| feat_en | input | 1 | Accelerator-data feature present |
| src_regs | input | 512 | Source registers t+7 down to t, concatenated |
| accdata | input | 32 | Accelerator-data register |
| base_gpr | input | 64 | Value of register Xn |
| sp | input | 64 | Stack pointer value |
| busy | output | 1 | Operation in progress |
| fault_valid | output | 1 | One-cycle fault pulse |
| fault_code | output | 2 | 1 illegal, 2 stack misaligned, 3 misaligned |
| mem_req_valid | output | 1 | Store request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Store address |
| mem_req_data | output | 512 | Store payload |
| mem_req_tag_check | output | 1 | Tag checking enabled for this access |
| mem_rsp_valid | input | 1 | Status response valid |
| mem_rsp_status | input | 64 | Status returned by the responder |
| wb_valid | output | 1 | Status write-back valid |
| wb_idx | output | 5 | Write-back register index |
| wb_data | output | 64 | Write-back status value |
| op_done | output | 1 | Completion pulse for a non-faulting operation |

## Verification
The hardest case to reach is a start that would be observably wrong if it took effect. This includes a new `op_start` raised while a response is still pending, and register inputs that change while the request is stalled. The bench reaches these by holding `mem_req_ready` and `mem_rsp_valid` low for random numbers of cycles. During those stalls it scrambles every register input and keeps `op_start` asserted. It then checks that the request contents still match the captured values and that no second request or fault appears.

// File: rtl/st64_pkg.sv
package st64_pkg;
    localparam int DW_BITS   = 64;
    localparam int N_DW      = 8;
    localparam int ACC_BITS  = 32;
    localparam int IDX_BITS  = 5;
    localparam int ALIGN_LSB = 6;
    localparam int SP_LSB    = 4;
    localparam int PAY_BITS  = DW_BITS * N_DW;
    localparam logic [IDX_BITS-1:0] ZERO_IDX = '1;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_ILLEGAL  = 2'd1,
        FLT_SP_ALIGN = 2'd2,
        FLT_MISALIGN = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        S_IDLE, S_FAULT, S_REQ, S_WAIT, S_DONE
    } state_e;
endpackage

// File: rtl/st64_check.sv
module st64_check
    import st64_pkg::*;
(
    input  logic                feat_en,
    input  logic [IDX_BITS-1:0] rt,
    input  logic [IDX_BITS-1:0] rn,
    input  logic [DW_BITS-1:0]  base_gpr,
    input  logic [DW_BITS-1:0]  sp,
    output logic [DW_BITS-1:0]  addr,
    output logic                tag_check,
    output fault_e              fault
);
    logic use_sp;
    logic bad_rt;

    assign use_sp    = (rn == ZERO_IDX);
    assign bad_rt    = (rt[4:3] == 2'b11) || rt[0];
    assign addr      = use_sp ? sp : base_gpr;
    assign tag_check = !use_sp;

    always_comb begin
        if (!feat_en || bad_rt)
            fault = FLT_ILLEGAL;
        else if (use_sp && (sp[SP_LSB-1:0] != '0))
            fault = FLT_SP_ALIGN;
        else if (addr[ALIGN_LSB-1:0] != '0)
            fault = FLT_MISALIGN;
        else
            fault = FLT_NONE;
    end
endmodule

// File: rtl/st64_pack.sv
module st64_pack
    import st64_pkg::*;
(
    input  logic [PAY_BITS-1:0] src_regs,
    input  logic [ACC_BITS-1:0] accdata,
    input  logic                big_endian,
    output logic [PAY_BITS-1:0] payload
);
    localparam int NBYTES = DW_BITS / 8;

    logic [PAY_BITS-1:0] merged;
    assign merged = {src_regs[PAY_BITS-1:ACC_BITS], accdata};

    for (genvar d = 0; d < N_DW; d++) begin : g_dw
        logic [DW_BITS-1:0] word;
        logic [DW_BITS-1:0] swapped;
        assign word = merged[d*DW_BITS +: DW_BITS];
        for (genvar b = 0; b < NBYTES; b++) begin : g_byte
            assign swapped[b*8 +: 8] = word[(NBYTES-1-b)*8 +: 8];
        end
        assign payload[d*DW_BITS +: DW_BITS] = big_endian ? swapped : word;
    end
endmodule

// File: rtl/st64_issue_unit.sv
module st64_issue_unit
    import st64_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_start,
    input  logic [4:0]          op_rs,
    input  logic [4:0]          op_rt,
    input  logic [4:0]          op_rn,
    input  logic                big_endian,
    input  logic                feat_en,
    input  logic [511:0]        src_regs,
    input  logic [31:0]         accdata,
    input  logic [63:0]         base_gpr,
    input  logic [63:0]         sp,
    output logic                busy,
    output logic                fault_valid,
    output logic [1:0]          fault_code,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [63:0]         mem_req_addr,
    output logic [511:0]        mem_req_data,
    output logic                mem_req_tag_check,
    input  logic                mem_rsp_valid,
    input  logic [63:0]         mem_rsp_status,
    output logic                wb_valid,
    output logic [4:0]          wb_idx,
    output logic [63:0]         wb_data,
    output logic                op_done
);
    state_e              state_q, state_d;
    fault_e              chk_fault;
    fault_e              fault_q;
    logic [DW_BITS-1:0]  chk_addr, addr_q, status_q;
    logic                chk_tag, tag_q;
    logic [PAY_BITS-1:0] pay, pay_q;
    logic [IDX_BITS-1:0] rs_q;
    logic                accept;

    st64_check u_check (
        .feat_en   (feat_en),
        .rt        (op_rt),
        .rn        (op_rn),
        .base_gpr  (base_gpr),
        .sp        (sp),
        .addr      (chk_addr),
        .tag_check (chk_tag),
        .fault     (chk_fault)
    );

    st64_pack u_pack (
        .src_regs   (src_regs),
        .accdata    (accdata),
        .big_endian (big_endian),
        .payload    (pay)
    );

    assign accept = (state_q == S_IDLE) && op_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_q  <= FLT_NONE;
            addr_q   <= '0;
            tag_q    <= 1'b0;
            pay_q    <= '0;
            rs_q     <= '0;
            status_q <= '0;
        end else begin
            if (accept) begin
                fault_q <= chk_fault;
                addr_q  <= chk_addr;
                tag_q   <= chk_tag;
                pay_q   <= pay;
                rs_q    <= op_rs;
            end
            if (state_q == S_WAIT && mem_rsp_valid)
                status_q <= mem_rsp_status;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (op_start) state_d = (chk_fault != FLT_NONE) ? S_FAULT : S_REQ;
            S_FAULT: state_d = S_IDLE;
            S_REQ:   if (mem_req_ready) state_d = S_WAIT;
            S_WAIT:  if (mem_rsp_valid) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        busy              = (state_q != S_IDLE);
        fault_valid       = (state_q == S_FAULT);
        fault_code        = (state_q == S_FAULT) ? fault_q : FLT_NONE;
        mem_req_valid     = (state_q == S_REQ);
        mem_req_addr      = addr_q;
        mem_req_data      = pay_q;
        mem_req_tag_check = tag_q;
        op_done           = (state_q == S_DONE);
        wb_valid          = (state_q == S_DONE) && (rs_q != ZERO_IDX);
        wb_idx            = rs_q;
        wb_data           = status_q;
    end
endmodule

// File: rtl/st64_issue_chk.sv
module st64_issue_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         busy,
    input logic         fault_valid,
    input logic         mem_req_valid,
    input logic         mem_req_ready,
    input logic [63:0]  mem_req_addr,
    input logic [511:0] mem_req_data,
    input logic         mem_rsp_valid,
    input logic [63:0]  mem_rsp_status,
    input logic         wb_valid,
    input logic [4:0]   wb_idx,
    input logic [63:0]  wb_data,
    input logic         op_done
);
    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data)));

    // R7
    req_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[5:0] == 6'd0));

    // R2
    fault_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (!mem_req_valid && !op_done));

    // R9
    wb_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> ($past(mem_rsp_valid) && wb_data == $past(mem_rsp_status)));

    // R10
    wb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_idx != 5'd31 && op_done));

    // R11
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || fault_valid || op_done) |-> busy);
endmodule

bind st64_issue_unit st64_issue_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .busy           (busy),
    .fault_valid    (fault_valid),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_addr   (mem_req_addr),
    .mem_req_data   (mem_req_data),
    .mem_rsp_valid  (mem_rsp_valid),
    .mem_rsp_status (mem_rsp_status),
    .wb_valid       (wb_valid),
    .wb_idx         (wb_idx),
    .wb_data        (wb_data),
    .op_done        (op_done)
);

// File: tb/sim_st64_issue_unit.sv
`timescale 1ns/1ps
module sim_st64_issue_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_start = 1'b0;
    logic [4:0]   op_rs = '0, op_rt = '0, op_rn = '0;
    logic         big_endian = 1'b0, feat_en = 1'b1;
    logic [511:0] src_regs = '0;
    logic [31:0]  accdata = '0;
    logic [63:0]  base_gpr = '0, sp = '0;
    logic         busy, fault_valid, mem_req_valid, mem_req_tag_check;
    logic [1:0]   fault_code;
    logic         mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
    logic [63:0]  mem_req_addr, mem_rsp_status = '0, wb_data;
    logic [511:0] mem_req_data;
    logic         wb_valid, op_done;
    logic [4:0]   wb_idx;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    st64_issue_unit u0 (.*);

    task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] bswap(input logic [63:0] v);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[b*8 +: 8] = v[(7-b)*8 +: 8];
        return r;
    endfunction

    function automatic logic [511:0] exp_pay(input logic [511:0] s, input logic [31:0] a, input logic be);
        logic [511:0] m, r;
        m = {s[511:32], a};
        for (int d = 0; d < 8; d++) r[d*64 +: 64] = be ? bswap(m[d*64 +: 64]) : m[d*64 +: 64];
        return r;
    endfunction

    function automatic logic [1:0] exp_fault(input logic f, input logic [4:0] rt, input logic [4:0] rn,
                                             input logic [63:0] b, input logic [63:0] s);
        logic [63:0] ad;
        ad = (rn == 5'd31) ? s : b;
        if (!f || rt[4:3] == 2'b11 || rt[0]) return 2'd1;
        if (rn == 5'd31 && s[3:0] != 4'd0)  return 2'd2;
        if (ad[5:0] != 6'd0)                return 2'd3;
        return 2'd0;
    endfunction

    function automatic logic [511:0] rnd512();
        logic [511:0] r;
        for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    task automatic scramble();
        src_regs = rnd512(); accdata = $urandom;
        base_gpr = {$urandom, $urandom}; sp = {$urandom, $urandom};
        big_endian = ~big_endian; op_rs = op_rs + 5'd3; op_rn = op_rn ^ 5'd7;
    endtask

    task automatic run_op(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rn,
                          input logic be, input logic f, input logic [511:0] s, input logic [31:0] a,
                          input logic [63:0] b, input logic [63:0] stk,
                          input int rdly, input int sdly, input logic [63:0] st);
        logic [1:0]   ef;
        logic [511:0] ep;
        logic [63:0]  ea;
        @(negedge clk);
        op_rs = rs; op_rt = rt; op_rn = rn; big_endian = be; feat_en = f;
        src_regs = s; accdata = a; base_gpr = b; sp = stk; op_start = 1'b1;
        ef = exp_fault(f, rt, rn, b, stk);
        ep = exp_pay(s, a, be);
        ea = (rn == 5'd31) ? stk : b;
        @(negedge clk);
        op_start = 1'b0;
        if (ef != 2'd0) begin
            // R2 R3 R6 R7: fault code and no request
            chk("R7 fault_code", fault_code, ef);
            chk("R2 fault_valid", fault_valid, 1'b1);
            chk("R3 no request", mem_req_valid, 1'b0);
            @(negedge clk);
            chk("R11 idle after fault", busy, 1'b0);
        end else begin
            chk("R6 no fault", fault_valid, 1'b0);
            chk("R1 R4 payload", mem_req_data, ep);
            chk("R5 address", mem_req_addr, ea);
            chk("R5 tag check", mem_req_tag_check, rn != 5'd31);
            scramble();
            for (int i = 0; i < rdly; i++) begin
                @(negedge clk);
                chk("R8 valid held", mem_req_valid, 1'b1);
                chk("R12 payload captured", mem_req_data, ep);
                chk("R12 addr captured", mem_req_addr, ea);
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            chk("R11 busy waiting", busy, 1'b1);
            op_start = 1'b1;
            for (int i = 0; i < sdly; i++) begin
                @(negedge clk);
                chk("R11 start ignored", {mem_req_valid, fault_valid}, 2'b00);
            end
            op_start = 1'b0;
            mem_rsp_valid = 1'b1; mem_rsp_status = st;
            @(negedge clk);
            mem_rsp_valid = 1'b0; mem_rsp_status = {$urandom, $urandom};
            chk("R10 wb_valid", wb_valid, rs != 5'd31);
            chk("R10 op_done", op_done, 1'b1);
            if (rs != 5'd31) begin
                chk("R9 wb_idx", wb_idx, rs);
                chk("R9 wb_data", wb_data, st);
            end
            @(negedge clk);
            chk("R11 idle after done", {busy, op_done, wb_valid}, 3'b000);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 reset outputs", {busy, mem_req_valid, wb_valid, fault_valid, op_done}, 5'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 after release", {busy, mem_req_valid, wb_valid, fault_valid, op_done}, 5'd0);

        // directed corners
        run_op(5'd4, 5'd0, 5'd2, 1'b0, 1'b1, {8{64'h0123456789ABCDEF}}, 32'hCAFEF00D,
               64'h1000, 64'h0, 0, 0, 64'h5);
        run_op(5'd9, 5'd8, 5'd3, 1'b1, 1'b1, rnd512(), 32'h11223344,
               64'h2_0000_0040, 64'h0, 2, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        run_op(5'd31, 5'd16, 5'd31, 1'b0, 1'b1, rnd512(), 32'h5,
               64'h7, 64'h8000, 1, 2, 64'h33);
        run_op(5'd1, 5'd24, 5'd2, 1'b0, 1'b1, rnd512(), 32'h0, 64'h40, 64'h0, 0, 0, 64'h0);
        run_op(5'd1, 5'd3, 5'd2, 1'b0, 1'b1, rnd512(), 32'h0, 64'h40, 64'h0, 0, 0, 64'h0);
        run_op(5'd1, 5'd2, 5'd2, 1'b0, 1'b0, rnd512(), 32'h0, 64'h40, 64'h0, 0, 0, 64'h0);
        run_op(5'd1, 5'd2, 5'd31, 1'b0, 1'b1, rnd512(), 32'h0, 64'h40, 64'h1008, 0, 0, 64'h0);
        run_op(5'd1, 5'd2, 5'd31, 1'b0, 1'b1, rnd512(), 32'h0, 64'h40, 64'h1010, 0, 0, 64'h0);
        run_op(5'd1, 5'd2, 5'd5, 1'b0, 1'b1, rnd512(), 32'h0, 64'h44, 64'h1010, 0, 0, 64'h0);

        // constrained random
        for (int k = 0; k < 300; k++) begin
            logic [4:0]  rt, rn;
            logic [63:0] b, s;
            rt = ($urandom_range(0, 9) == 0) ? 5'($urandom) : 5'(2 * $urandom_range(0, 11));
            rn = ($urandom_range(0, 3) == 0) ? 5'd31 : 5'($urandom_range(0, 30));
            b  = {$urandom, $urandom};
            s  = {$urandom, $urandom};
            if ($urandom_range(0, 4) != 0) begin b[5:0] = 6'd0; s[5:0] = 6'd0; end
            run_op(5'($urandom), rt, rn, 1'($urandom), ($urandom_range(0, 15) != 0),
                   rnd512(), $urandom, b, s, $urandom_range(0, 4), $urandom_range(0, 4),
                   ($urandom_range(0, 7) == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : {$urandom, $urandom});
        end

        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            ended = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule